// File: doc/BRIEF.md
# Completion Timeout and Error Reporter

This block sits on the requester side of a PCI Express application layer and turns request/completion bookkeeping into single-cycle error pulses for the configuration-space error logic. Every non-posted request the application issues is entered into a tag table with its own countdown timer. A completion that carries the tag of a live entry retires it silently. A completion whose tag is not live is an unexpected completion. A live entry whose timer runs out is a completion timeout, reported as correctable or uncorrectable according to a per-cycle selector sampled at the moment of expiry.

The application can also report completer-abort and unsupported-request outcomes. Posted outcomes are pulsed at once. A non-posted outcome is held by a small state machine until the application signals that the error completion has left. The machine has three states. In `NP_IDLE`, an `np_err_valid` moves it to `NP_HOLD_CA` or `NP_HOLD_UR`, according to `np_err_is_ur`. In either hold state, `np_cpl_sent` releases the matching pulse and returns it to `NP_IDLE`. All error classes are registered once, so an event sampled on a clock edge shows up in the cycle that follows that edge.

Top module: `cpl_err_reporter`

## Requirements
- R1: After reset, `err_pulse` is all zero, `dup_req_cnt` is zero and no tag is outstanding, so the first completion for any tag is unexpected.
- R2: A request sampled with `req_valid` makes its tag outstanding. A completion for an outstanding tag retires it with no pulse, and a second completion for that tag is then unexpected.
- R3: A completion for a tag that is not outstanding pulses bit 3 in the cycle after the completion is sampled.
- R4: A request sampled at edge k with no completion through edge k+T-1 (T = `TIMEOUT_CYC`) expires at edge k+T. It pulses bit 0 if `to_recover` is high at that edge, and bit 1 if it is low. A completion sampled at edge k+T still retires the entry without a pulse.
- R5: A request for a tag that is already outstanding is ignored: the timer is not restarted. The request raises `dup_req_cnt` by one, and the counter saturates at all ones.
- R6: `ca_posted` pulses bit 2 and `ur_posted` pulses bit 4, each in the cycle after it is sampled.
- R7: `np_err_valid` in `NP_IDLE` holds a non-posted outcome, where `np_err_is_ur` = 0 means abort and 1 means unsupported request. The held outcome pulses bit 2 (abort) or bit 5 (unsupported) only in the cycle after `np_cpl_sent` is sampled. `np_cpl_sent` with nothing held has no effect.
- R8: While an outcome is held, a further `np_err_valid` is ignored.
- R9: Events of different classes sampled on one edge pulse their own bits in the same cycle. Two abort events on one edge give bit 2 in two consecutive cycles.
- R10: Bit 6 is always low, and each event produces a pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Non-posted request issued this cycle |
| req_tag | input | $clog2(NUM_TAGS) | Tag of the issued request |
| cpl_valid | input | 1 | Completion received this cycle |
| cpl_tag | input | $clog2(NUM_TAGS) | Tag carried by the completion |
| to_recover | input | 1 | An expiring request is correctable (bit 0) rather than uncorrectable (bit 1) |
| ca_posted | input | 1 | Completer abort for a posted request |
| ur_posted | input | 1 | Unsupported request for a posted request |
| np_err_valid | input | 1 | Non-posted request answered with an error completion |
| np_err_is_ur | input | 1 | Kind of that error: 0 abort, 1 unsupported request |
| np_cpl_sent | input | 1 | The error completion has been sent |
| err_pulse | output | 7 | One-cycle error pulses: 0 timeout correctable, 1 timeout uncorrectable, 2 completer abort, 3 unexpected completion, 4 posted unsupported, 5 non-posted unsupported, 6 reserved |
| dup_req_cnt | output | DUP_W | Saturating count of ignored duplicate requests |

## Verification
Two cases are hard to reach from the ports. The first is a deadline collision, where an expiry coincides with a completion or with events of every other class. The second is a same-class clash on bit 2. To reach both, the bench counts the cycles from each request exactly, using a short timeout. It places the completion, the posted reports and a pre-held non-posted release on the single edge on which the timer expires. For the abort clash, it holds a non-posted abort and then asserts `np_cpl_sent` together with `ca_posted`. It then expects bit 2 on two consecutive cycles and silence after.

// File: rtl/cto_pkg.sv
package cto_pkg;

    // Bit positions inside the error pulse vector; the consumer decodes them.
    localparam int ERR_W        = 7;
    localparam int ERR_TO_REC   = 0;
    localparam int ERR_TO_FATAL = 1;
    localparam int ERR_CA       = 2;
    localparam int ERR_UNEXP    = 3;
    localparam int ERR_UR_P     = 4;
    localparam int ERR_UR_NP    = 5;
    localparam int ERR_RSVD     = 6;

    typedef enum logic [1:0] {
        NP_IDLE    = 2'd0,
        NP_HOLD_CA = 2'd1,
        NP_HOLD_UR = 2'd2
    } np_state_e;

endpackage

// File: rtl/cto_tag_table.sv
module cto_tag_table #(
    parameter int NUM_TAGS    = 32,
    parameter int TIMEOUT_CYC = 12_500_000,
    localparam int TAG_W      = $clog2(NUM_TAGS),
    localparam int TMR_W      = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    output logic             unexp_evt,
    output logic             dup_evt,
    output logic             expire_evt
);

    logic [NUM_TAGS-1:0] vld_q;
    logic [NUM_TAGS-1:0] hit_cpl;
    logic [NUM_TAGS-1:0] hit_req;
    logic [NUM_TAGS-1:0] alloc;
    logic [NUM_TAGS-1:0] expire;

    for (genvar i = 0; i < NUM_TAGS; i++) begin : g_slot
        logic             live_q;
        logic [TMR_W-1:0] cnt_q;

        assign vld_q[i]   = live_q;
        assign hit_cpl[i] = cpl_valid && (cpl_tag == TAG_W'(i)) && live_q;
        assign hit_req[i] = req_valid && (req_tag == TAG_W'(i));
        // A completion retiring the slot frees it for a request on the same edge.
        assign alloc[i]   = hit_req[i] && (!live_q || hit_cpl[i]);
        assign expire[i]  = live_q && !hit_cpl[i] && (cnt_q == TMR_W'(1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_q <= 1'b0;
                cnt_q  <= '0;
            end else if (alloc[i]) begin
                live_q <= 1'b1;
                cnt_q  <= TMR_W'(TIMEOUT_CYC);
            end else if (hit_cpl[i] || expire[i]) begin
                live_q <= 1'b0;
                cnt_q  <= '0;
            end else if (live_q) begin
                cnt_q  <= cnt_q - TMR_W'(1);
            end
        end
    end

    assign unexp_evt  = cpl_valid && !(|hit_cpl);
    assign dup_evt    = |(hit_req & vld_q & ~hit_cpl);
    assign expire_evt = |expire;

endmodule

// File: rtl/cto_np_hold_fsm.sv
module cto_np_hold_fsm
    import cto_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic np_err_valid,
    input  logic np_err_is_ur,
    input  logic np_cpl_sent,
    output logic rel_ca,
    output logic rel_ur
);

    np_state_e state_q;
    np_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NP_IDLE: begin
                if (np_err_valid) begin
                    state_d = np_err_is_ur ? NP_HOLD_UR : NP_HOLD_CA;
                end
            end
            NP_HOLD_CA, NP_HOLD_UR: begin
                if (np_cpl_sent) begin
                    state_d = NP_IDLE;
                end
            end
            default: state_d = NP_IDLE;
        endcase
    end

    always_comb begin
        rel_ca = 1'b0;
        rel_ur = 1'b0;
        unique case (state_q)
            NP_IDLE:    ;
            NP_HOLD_CA: rel_ca = np_cpl_sent;
            NP_HOLD_UR: rel_ur = np_cpl_sent;
            default:    ;
        endcase
    end

endmodule

// File: rtl/cto_class_queue.sv
module cto_class_queue #(
    parameter int N_SRC  = 2,
    parameter int CNT_W  = 3,
    localparam int SUM_W = CNT_W + $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ev,
    output logic             fire
);

    localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

    logic [CNT_W-1:0] pend_q;
    logic [SUM_W-1:0] total;
    logic [SUM_W-1:0] rest;

    always_comb begin
        total = SUM_W'(pend_q);
        for (int k = 0; k < N_SRC; k++) begin
            total = total + SUM_W'(ev[k]);
        end
        fire = (total != '0);
        rest = total - SUM_W'(fire);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (rest > CNT_MAX) begin
            pend_q <= {CNT_W{1'b1}};
        end else begin
            pend_q <= rest[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/cpl_err_reporter.sv
module cpl_err_reporter
    import cto_pkg::*;
#(
    parameter int NUM_TAGS    = 32,
    parameter int TIMEOUT_CYC = 12_500_000,
    parameter int DUP_W       = 8,
    parameter int CA_Q_W      = 3,
    localparam int TAG_W      = $clog2(NUM_TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic             to_recover,
    input  logic             ca_posted,
    input  logic             ur_posted,
    input  logic             np_err_valid,
    input  logic             np_err_is_ur,
    input  logic             np_cpl_sent,
    output logic [6:0]       err_pulse,
    output logic [DUP_W-1:0] dup_req_cnt
);

    logic             unexp_evt;
    logic             dup_evt;
    logic             expire_evt;
    logic             rel_ca;
    logic             rel_ur;
    logic             ca_fire;
    logic [ERR_W-1:0] err_d;

    cto_tag_table #(
        .NUM_TAGS   (NUM_TAGS),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_tag   (req_tag),
        .cpl_valid (cpl_valid),
        .cpl_tag   (cpl_tag),
        .unexp_evt (unexp_evt),
        .dup_evt   (dup_evt),
        .expire_evt(expire_evt)
    );

    cto_np_hold_fsm u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .np_err_valid(np_err_valid),
        .np_err_is_ur(np_err_is_ur),
        .np_cpl_sent (np_cpl_sent),
        .rel_ca      (rel_ca),
        .rel_ur      (rel_ur)
    );

    // Only the abort class has two sources that can fire on one edge.
    cto_class_queue #(
        .N_SRC(2),
        .CNT_W(CA_Q_W)
    ) u_ca_q (
        .clk  (clk),
        .rst_n(rst_n),
        .ev   ({rel_ca, ca_posted}),
        .fire (ca_fire)
    );

    always_comb begin
        err_d               = '0;
        err_d[ERR_TO_REC]   = expire_evt && to_recover;
        err_d[ERR_TO_FATAL] = expire_evt && !to_recover;
        err_d[ERR_CA]       = ca_fire;
        err_d[ERR_UNEXP]    = unexp_evt;
        err_d[ERR_UR_P]     = ur_posted;
        err_d[ERR_UR_NP]    = rel_ur;
        err_d[ERR_RSVD]     = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_pulse   <= '0;
            dup_req_cnt <= '0;
        end else begin
            err_pulse <= err_d;
            if (dup_evt && (dup_req_cnt != {DUP_W{1'b1}})) begin
                dup_req_cnt <= dup_req_cnt + DUP_W'(1);
            end
        end
    end

endmodule

// File: rtl/cpl_err_reporter_chk.sv
module cpl_err_reporter_chk #(
    parameter int DUP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpl_valid,
    input logic             ur_posted,
    input logic             np_cpl_sent,
    input logic [6:0]       err_pulse,
    input logic [DUP_W-1:0] dup_req_cnt
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R10
    rsvd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse[6] == 1'b0);

    // R3
    unexp_needs_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        err_pulse[3] |-> $past(cpl_valid));

    // R6
    ur_posted_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(ur_posted) |-> err_pulse[4]);

    // R6
    ur_posted_src_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        err_pulse[4] |-> $past(ur_posted));

    // R7
    np_ur_after_sent_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        err_pulse[5] |-> $past(np_cpl_sent));

    // R4
    timeout_one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_pulse[0] && err_pulse[1]));

    // R5
    dup_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        dup_req_cnt >= $past(dup_req_cnt));

endmodule

bind cpl_err_reporter cpl_err_reporter_chk #(.DUP_W(DUP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpl_valid  (cpl_valid),
    .ur_posted  (ur_posted),
    .np_cpl_sent(np_cpl_sent),
    .err_pulse  (err_pulse),
    .dup_req_cnt(dup_req_cnt)
);

// File: tb/sim_cpl_err_reporter.sv
module sim_cpl_err_reporter;

    localparam int CLK_PERIOD = 10;
    localparam int NT         = 8;
    localparam int T          = 20;
    localparam int TW         = $clog2(NT);
    localparam int DW         = 8;

    localparam logic [6:0] E_NONE  = 7'b0000000;
    localparam logic [6:0] E_TOR   = 7'b0000001;
    localparam logic [6:0] E_TOF   = 7'b0000010;
    localparam logic [6:0] E_CA    = 7'b0000100;
    localparam logic [6:0] E_UNEXP = 7'b0001000;
    localparam logic [6:0] E_URP   = 7'b0010000;
    localparam logic [6:0] E_URNP  = 7'b0100000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, cpl_valid, to_recover, ca_posted, ur_posted;
    logic          np_err_valid, np_err_is_ur, np_cpl_sent;
    logic [TW-1:0] req_tag, cpl_tag;
    logic [6:0]    err_pulse;
    logic [DW-1:0] dup_req_cnt;

    int  n_run  = 0;
    int  n_fail = 0;
    int  exp_dup = 0;
    bit  done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cpl_err_reporter #(
        .NUM_TAGS   (NT),
        .TIMEOUT_CYC(T),
        .DUP_W      (DW)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_tag(req_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .to_recover(to_recover), .ca_posted(ca_posted), .ur_posted(ur_posted),
        .np_err_valid(np_err_valid), .np_err_is_ur(np_err_is_ur),
        .np_cpl_sent(np_cpl_sent),
        .err_pulse(err_pulse), .dup_req_cnt(dup_req_cnt)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Pulse inputs clear; to_recover is held by the caller.
    task automatic idle();
        req_valid = 0; cpl_valid = 0; ca_posted = 0; ur_posted = 0;
        np_err_valid = 0; np_err_is_ur = 0; np_cpl_sent = 0;
    endtask

    // Apply the current inputs on one edge, then look at the result after it.
    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic chk(input string r, input logic [6:0] exp);
        n_run++;
        if (err_pulse !== exp) begin
            n_fail++;
            $display("FAIL %s: err_pulse=%b expected %b", r, err_pulse, exp);
        end
    endtask

    task automatic chk_dup(input string r);
        n_run++;
        if (dup_req_cnt !== DW'(exp_dup)) begin
            n_fail++;
            $display("FAIL %s: dup_req_cnt=%0d expected %0d", r, dup_req_cnt, exp_dup);
        end
    endtask

    task automatic wait_quiet(input int n, input string r);
        for (int k = 0; k < n; k++) begin
            tick();
            chk(r, E_NONE);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; to_recover = 0; req_tag = '0; cpl_tag = '0;
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1", E_NONE);
        chk_dup("R1");

        // R1 / R3: every tag is empty after reset, so completions are unexpected
        for (int t = 0; t < NT; t++) begin
            cpl_valid = 1; cpl_tag = TW'(t);
            tick();
            chk((t == 0) ? "R1" : "R3", E_UNEXP);
            tick();
            chk("R10", E_NONE);
        end

        // R2: request then matching completion retires silently; repeat is unexpected
        for (int t = 0; t < NT; t++) begin
            req_valid = 1; req_tag = TW'(t);
            tick();
            chk("R2", E_NONE);
            wait_quiet(t, "R2");
            cpl_valid = 1; cpl_tag = TW'(t);
            tick();
            chk("R2", E_NONE);
            cpl_valid = 1; cpl_tag = TW'(t);
            tick();
            chk("R2", E_UNEXP);
        end

        // R4: expiry exactly T edges after the request, class chosen by to_recover
        for (int t = 0; t < NT; t++) begin
            to_recover = t[0];
            req_valid = 1; req_tag = TW'(t);
            tick();
            wait_quiet(T - 1, "R4");
            tick();
            chk("R4", t[0] ? E_TOR : E_TOF);
            tick();
            chk("R10", E_NONE);
        end
        to_recover = 0;

        // R4: completion on the deadline edge wins
        req_valid = 1; req_tag = TW'(5);
        tick();
        wait_quiet(T - 1, "R4");
        cpl_valid = 1; cpl_tag = TW'(5);
        tick();
        chk("R4", E_NONE);
        cpl_valid = 1; cpl_tag = TW'(5);
        tick();
        chk("R4", E_UNEXP);

        // R5: duplicate request is counted and does not restart the timer
        req_valid = 1; req_tag = TW'(2);
        tick();
        wait_quiet(4, "R5");
        req_valid = 1; req_tag = TW'(2);
        tick();
        exp_dup++;
        chk("R5", E_NONE);
        chk_dup("R5");
        wait_quiet(T - 6, "R5");
        tick();
        chk("R5", E_TOF);
        req_valid = 1; req_tag = TW'(2);
        tick();
        chk_dup("R5");
        cpl_valid = 1; cpl_tag = TW'(2);
        tick();
        chk("R5", E_NONE);

        // R6: posted outcomes
        ca_posted = 1;
        tick();
        chk("R6", E_CA);
        tick();
        chk("R10", E_NONE);
        ur_posted = 1;
        tick();
        chk("R6", E_URP);
        tick();
        chk("R10", E_NONE);

        // R7: held non-posted outcomes, sweep both kinds
        for (int kind = 0; kind < 2; kind++) begin
            np_cpl_sent = 1;
            tick();
            chk("R7", E_NONE);
            np_err_valid = 1; np_err_is_ur = kind[0];
            tick();
            chk("R7", E_NONE);
            wait_quiet(3, "R7");
            np_cpl_sent = 1;
            tick();
            chk("R7", kind[0] ? E_URNP : E_CA);
            np_cpl_sent = 1;
            tick();
            chk("R7", E_NONE);
        end

        // R8: second report while holding is dropped
        np_err_valid = 1; np_err_is_ur = 0;
        tick();
        np_err_valid = 1; np_err_is_ur = 1;
        tick();
        chk("R8", E_NONE);
        np_cpl_sent = 1;
        tick();
        chk("R8", E_CA);
        np_cpl_sent = 1;
        tick();
        chk("R8", E_NONE);

        // R9: two aborts on one edge give two consecutive pulses
        np_err_valid = 1; np_err_is_ur = 0;
        tick();
        ca_posted = 1; np_cpl_sent = 1;
        tick();
        chk("R9", E_CA);
        tick();
        chk("R9", E_CA);
        tick();
        chk("R9", E_NONE);

        // R9: every class on the expiry edge
        np_err_valid = 1; np_err_is_ur = 1;
        tick();
        to_recover = 1;
        req_valid = 1; req_tag = TW'(1);
        tick();
        wait_quiet(T - 1, "R9");
        cpl_valid = 1; cpl_tag = TW'(6);
        ur_posted = 1; ca_posted = 1; np_cpl_sent = 1;
        tick();
        chk("R9", E_TOR | E_CA | E_UNEXP | E_URP | E_URNP);
        tick();
        chk("R10", E_NONE);
        to_recover = 0;
        chk_dup("R5");

        done = 1;
        summary();
        $finish;
    end

endmodule